// File: doc/BRIEF.md
# SPI NOR flash command engine

This block is the device side of a serial NOR flash. It receives SPI mode 0 traffic, with data taken on the rising edge of `sck`, most significant bit first. It decodes the opcode and collects the address bytes, then either streams data back on `miso` or takes program data in. The storage is a small array of byte registers. The array is split into pages for programming and into sectors for erasing.

A write-enable latch in the status register guards every command that changes the array or the status register. A hardware write-protect pin, together with the top status bit, can lock the status register. The host can switch addressing from three bytes to four bytes. A reset sequence of two commands returns the volatile state to its power-on values.

The serial pins are sampled in the `clk` domain, so `sck` must run well below `clk`. Changes to state happen when chip select rises at the end of a transaction. Program data is the one exception: each program byte is committed as it arrives.

Top module: `nor_cmd_engine`

## Requirements
- R1: After `rst_n` is released, `miso` is 0, a status read returns 0x00, the array reads 0xFF everywhere, and addressing uses 3 bytes.
- R2: Opcode 0x9F returns the bytes 0x20, 0xBA and 0x19 in that order, followed by 0x00 for any further byte.
- R3: Opcode 0x05 returns the status byte, and repeats it for as long as the host keeps clocking. Bit 0 reads 0, bit 1 is the write-enable latch, and bits 7:2 are the stored status bits. Opcode 0x06 sets the latch and opcode 0x04 clears it.
- R4: Opcode 0x01 followed by one data byte loads data bits 7:2 into status bits 7:2, but only if the latch is set. The write is refused, leaving those bits unchanged, when status bit 7 is 1 and `wp_n` is 0. A write attempted with the latch set clears the latch, whether it succeeds or is refused. Without the latch set, the command is ignored.
- R5: Opcode 0x03 followed by an address (MSB first) returns the array byte at that address. It then continues through consecutive addresses for as long as chip select stays low, and wraps from the last byte of the array to address 0. Address bits above the array size are ignored.
- R6: Opcode 0x02 followed by an address, with the latch set, ANDs each data byte into the array. The offset wraps within the 256-byte page, and the latch is cleared at the end. Without the latch set, the array is not changed.
- R7: Opcode 0xD8 followed by an address, with the latch set, sets every byte of the 512-byte sector that holds the address to 0xFF and clears the latch. Other sectors are not changed. Without the latch set, the command has no effect.
- R8: Opcode 0xC7 with the latch set sets the whole array to 0xFF and clears the latch. Without the latch set, it has no effect.
- R9: After opcode 0xB7, every address is 4 bytes, MSB first. Before it, every address is 3 bytes.
- R10: Opcode 0x99 clears the latch and returns to 3-byte addressing only when the transaction directly before it was opcode 0x66. In any other case it has no effect. It never changes the array or status bits 7:2.
- R11: A transaction whose chip select rises after a partial byte has no effect on the latch, the status bits or the address mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host, mode 0 |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, changes after `sck` falls |
| wp_n | input | 1 | Write-protect pin, active low |

## Verification
The assertions take for granted that `sck` toggles only while `cs_n` is low. They also assume each `sck` level lasts at least one `clk` cycle, and that `cs_n` and `wp_n` change only while `sck` is low. Under these conditions, every state change from a command lands on the cycle after chip select rises. The bench drives each half period of `sck` for two `clk` cycles and moves `cs_n` with `sck` held low. It draws `wp_n` values, addresses, lengths and opcodes at random between transactions, never inside one.

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine #(
  parameter int MEM_BYTES = 1024,
  parameter int PAGE_BYTES = 256,
  parameter int SECTOR_BYTES = 512,
  parameter logic [23:0] DEV_ID = 24'h20BA19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  input  logic wp_n
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int SW = $clog2(SECTOR_BYTES);
  localparam logic [AW-1:0] PMASK = AW'(PAGE_BYTES - 1);

  localparam logic [7:0] OP_RDID = 8'h9F, OP_RDSR = 8'h05, OP_WRSR = 8'h01,
                         OP_WREN = 8'h06, OP_WRDI = 8'h04, OP_READ = 8'h03,
                         OP_PP   = 8'h02, OP_SE   = 8'hD8, OP_BE   = 8'hC7,
                         OP_EN4B = 8'hB7, OP_RSTEN = 8'h66, OP_RST = 8'h99;

  logic          sck_q, cs_q;
  logic [2:0]    bitcnt;
  logic [6:0]    rx;
  logic [3:0]    nbytes;
  logic [7:0]    opcode;
  logic [AW-1:0] addr, ptr;
  logic [7:0]    tx;
  logic [1:0]    id_idx;
  logic [5:0]    sr_hi, sr_data;
  logic          wel, four_b, armed;
  logic [7:0]    mem [MEM_BYTES];

  logic sck_rise, sck_fall, cs_end, byte_done, aligned_end;
  logic [7:0]    rx_byte, status;
  logic [3:0]    nab;
  logic [AW-1:0] full_addr, ptr_page_next;
  logic prog_we, se_go, be_go, wrsr_go;

  assign sck_rise      = ~cs_n & sck & ~sck_q;
  assign sck_fall      = ~cs_n & ~sck & sck_q;
  assign cs_end        = cs_n & ~cs_q;
  assign byte_done     = sck_rise && bitcnt == 3'd7;
  assign rx_byte       = {rx, mosi};
  assign nab           = four_b ? 4'd4 : 4'd3;
  assign full_addr     = AW'({addr, rx_byte});
  assign ptr_page_next = (ptr & ~PMASK) | ((ptr + 1'b1) & PMASK);
  assign status        = {sr_hi, wel, 1'b0};
  assign aligned_end   = cs_end && bitcnt == 3'd0 && nbytes != 4'd0;
  assign prog_we       = byte_done && nbytes != 4'd0 && opcode == OP_PP && nbytes > nab && wel;
  assign se_go         = aligned_end && opcode == OP_SE && wel && nbytes > nab;
  assign be_go         = aligned_end && opcode == OP_BE && wel;
  assign wrsr_go       = aligned_end && opcode == OP_WRSR && wel && nbytes >= 4'd2;
  assign miso          = ~cs_n & tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1;
      bitcnt <= '0; rx <= '0; nbytes <= '0; opcode <= '0;
      addr <= '0; ptr <= '0; tx <= '0; id_idx <= '0;
      sr_hi <= '0; sr_data <= '0; wel <= 1'b0; four_b <= 1'b0; armed <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        bitcnt <= '0; rx <= '0; nbytes <= '0; addr <= '0; tx <= '0; id_idx <= '0;
      end else begin
        if (sck_rise) begin
          bitcnt <= bitcnt + 3'd1;
          rx     <= {rx[5:0], mosi};
        end
        if (sck_fall && bitcnt != 3'd0)
          tx <= {tx[6:0], 1'b0};
        if (byte_done) begin
          if (nbytes != 4'hF) nbytes <= nbytes + 4'd1;
          if (nbytes == 4'd0) begin
            opcode <= rx_byte;
            case (rx_byte)
              OP_RDID: begin tx <= DEV_ID[23:16]; id_idx <= 2'd1; end
              OP_RDSR: tx <= status;
              default: tx <= 8'h00;
            endcase
          end else begin
            if (nbytes <= nab) addr <= full_addr;
            case (opcode)
              OP_RDID: begin
                tx <= (id_idx == 2'd1) ? DEV_ID[15:8] :
                      (id_idx == 2'd2) ? DEV_ID[7:0] : 8'h00;
                if (id_idx != 2'd3) id_idx <= id_idx + 2'd1;
              end
              OP_RDSR: tx <= status;
              OP_READ: begin
                if (nbytes == nab) begin
                  tx  <= mem[full_addr];
                  ptr <= full_addr + 1'b1;
                end else if (nbytes > nab) begin
                  tx  <= mem[ptr];
                  ptr <= ptr + 1'b1;
                end
              end
              OP_PP: begin
                if (nbytes == nab) ptr <= full_addr;
                else if (nbytes > nab) ptr <= ptr_page_next;
              end
              OP_SE: if (nbytes == nab) ptr <= full_addr;
              OP_WRSR: if (nbytes == 4'd1) sr_data <= rx_byte[7:2];
              default: ;
            endcase
          end
        end
      end

      if (aligned_end) begin
        armed <= (opcode == OP_RSTEN);
        case (opcode)
          OP_WREN: wel <= 1'b1;
          OP_WRDI: wel <= 1'b0;
          OP_EN4B: four_b <= 1'b1;
          OP_PP:   wel <= 1'b0;
          OP_RST:  if (armed) begin wel <= 1'b0; four_b <= 1'b0; end
          default: ;
        endcase
        if (se_go || be_go) wel <= 1'b0;
        if (wrsr_go) begin
          wel <= 1'b0;
          if (!(sr_hi[5] && !wp_n)) sr_hi <= sr_data;
        end
      end else if (cs_end && (bitcnt != 3'd0 || nbytes != 4'd0)) begin
        armed <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < MEM_BYTES; i++)
        if (be_go || (se_go && (AW'(i) >> SW) == (ptr >> SW)))
          mem[i] <= 8'hFF;
      if (prog_we) mem[ptr] <= mem[ptr] & rx_byte;
    end
  end
endmodule

// File: rtl/nor_cmd_engine_sva.sv
module nor_cmd_engine_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       wp_n,
  input logic       wel,
  input logic       four_b,
  input logic [5:0] sr_hi
);
  // R3
  wel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_n));

  // R11
  wel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> $stable(wel));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> $stable(four_b));

  // R4
  sr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_hi[5] && !wp_n) |=> $stable(sr_hi));

  // R10
  mode_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(four_b) |-> $past(cs_n));
endmodule

bind nor_cmd_engine nor_cmd_engine_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
  .wel(wel), .four_b(four_b), .sr_hi(sr_hi)
);

// File: tb/nor_cmd_engine_test.sv
module nor_cmd_engine_test;
  localparam int MEM = 1024;
  localparam int PAGE = 256;
  localparam int SEC = 512;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
  logic miso;

  nor_cmd_engine uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
                      .mosi(mosi), .miso(miso), .wp_n(wp_n));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] ref_mem [MEM];
  logic       ref_wel = 1'b0, ref_4b = 1'b0, ref_armed = 1'b0;
  logic [5:0] ref_sr = '0;
  logic [7:0] pbuf [300];
  logic [7:0] junk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xbit(input logic b, output logic q);
    mosi = b; tick(2); q = miso;
    sck = 1'b1; tick(2); sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) xbit(d[i], q[i]);
  endtask

  task automatic cs_lo; cs_n = 1'b0; tick(2); endtask
  task automatic cs_hi; tick(2); cs_n = 1'b1; tick(3); endtask

  task automatic send_addr(input logic [31:0] a);
    if (ref_4b) xbyte(a[31:24], junk);
    xbyte(a[23:16], junk); xbyte(a[15:8], junk); xbyte(a[7:0], junk);
  endtask

  task automatic op_simple(input logic [7:0] op);
    logic nxt;
    cs_lo; xbyte(op, junk); cs_hi;
    nxt = (op == 8'h66);
    case (op)
      8'h06: ref_wel = 1'b1;
      8'h04: ref_wel = 1'b0;
      8'hB7: ref_4b = 1'b1;
      8'h99: if (ref_armed) begin ref_wel = 1'b0; ref_4b = 1'b0; end
      8'hC7: if (ref_wel) begin
        for (int i = 0; i < MEM; i++) ref_mem[i] = 8'hFF;
        ref_wel = 1'b0;
      end
      default: ;
    endcase
    ref_armed = nxt;
  endtask

  task automatic chk_status(input string tag);
    logic [7:0] s;
    cs_lo; xbyte(8'h05, junk); xbyte(8'h00, s); cs_hi;
    ref_armed = 1'b0;
    check(s, {ref_sr, ref_wel, 1'b0}, tag);
  endtask

  task automatic wrsr(input logic [7:0] v);
    cs_lo; xbyte(8'h01, junk); xbyte(v, junk); cs_hi;
    if (ref_wel) begin
      if (!(ref_sr[5] && !wp_n)) ref_sr = v[7:2];
      ref_wel = 1'b0;
    end
    ref_armed = 1'b0;
  endtask

  task automatic rd_check(input logic [31:0] a, input int n, input string tag);
    logic [7:0] q;
    cs_lo; xbyte(8'h03, junk); send_addr(a);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, q);
      check(q, ref_mem[(int'(a % MEM) + i) % MEM], tag);
    end
    cs_hi;
    ref_armed = 1'b0;
  endtask

  task automatic pp(input logic [31:0] a, input int n);
    int base;
    cs_lo; xbyte(8'h02, junk); send_addr(a);
    base = int'(a % MEM) & ~(PAGE - 1);
    for (int i = 0; i < n; i++) begin
      xbyte(pbuf[i], junk);
      if (ref_wel) ref_mem[base + ((int'(a % PAGE) + i) % PAGE)] &= pbuf[i];
    end
    cs_hi;
    ref_wel = 1'b0;
    ref_armed = 1'b0;
  endtask

  task automatic se(input logic [31:0] a);
    int base;
    cs_lo; xbyte(8'hD8, junk); send_addr(a); cs_hi;
    if (ref_wel) begin
      base = (int'(a % MEM) / SEC) * SEC;
      for (int i = 0; i < SEC; i++) ref_mem[base + i] = 8'hFF;
      ref_wel = 1'b0;
    end
    ref_armed = 1'b0;
  endtask

  task automatic fill(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) pbuf[i] = seed ^ 8'(i * 37);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] q;
    int unsigned sv;
    sv = $urandom(32'h5EED1234);
    for (int i = 0; i < MEM; i++) ref_mem[i] = 8'hFF;
    tick(3); rst_n = 1'b1; tick(3);

    // R1 reset state
    check(miso, 0, "R1 miso idle");
    chk_status("R1 status after reset");
    rd_check(32'h10, 4, "R1 erased array");

    // R2 identification
    cs_lo; xbyte(8'h9F, junk);
    xbyte(0, q); check(q, 8'h20, "R2 id byte0");
    xbyte(0, q); check(q, 8'hBA, "R2 id byte1");
    xbyte(0, q); check(q, 8'h19, "R2 id byte2");
    xbyte(0, q); check(q, 8'h00, "R2 id tail");
    cs_hi; ref_armed = 1'b0;

    // R3 latch set / clear, repeated status
    op_simple(8'h06); chk_status("R3 after set");
    cs_lo; xbyte(8'h05, junk); xbyte(0, q); xbyte(0, q);
    check(q, 8'h02, "R3 repeated status"); cs_hi;
    op_simple(8'h04); chk_status("R3 after clear");

    // R6 program without latch
    fill(8, 8'h00); pp(32'h100, 8);
    rd_check(32'h100, 8, "R6 no latch no change");

    // R6 page wrap and latch clear
    op_simple(8'h06); fill(32, 8'h5A); pp(32'h1F0, 32);
    chk_status("R6 latch cleared");
    rd_check(32'h1F0, 16, "R6 page tail");
    rd_check(32'h100, 16, "R6 page wrap head");
    rd_check(32'h200, 2, "R6 next page untouched");
    op_simple(8'h06); fill(32, 8'hC3); pp(32'h1F0, 32);
    rd_check(32'h1F0, 16, "R6 AND program");

    // R5 wrap at end of array, high address bits ignored
    op_simple(8'h06); fill(4, 8'h11); pp(32'h3FE, 4);
    rd_check(MEM - 2, 5, "R5 array wrap");
    rd_check(32'hAB0100, 3, "R5 high bits ignored");

    // R7 sector erase
    op_simple(8'h06); fill(8, 8'h22); pp(32'h210, 8);
    se(32'h100); rd_check(32'h100, 4, "R7 no latch no erase");
    op_simple(8'h06); se(32'h1FF);
    rd_check(32'h1F0, 16, "R7 sector erased");
    rd_check(32'h210, 8, "R7 other sector kept");
    chk_status("R7 latch cleared");

    // R4 status write protection
    op_simple(8'h06); wrsr(8'h80); chk_status("R4 set srwd wp high");
    op_simple(8'h06); wrsr(8'h00); chk_status("R4 clear srwd wp high");
    wp_n = 1'b0;
    op_simple(8'h06); wrsr(8'h84); chk_status("R4 set srwd wp low");
    op_simple(8'h06); wrsr(8'h00); chk_status("R4 refused wp low");
    wp_n = 1'b1;
    op_simple(8'h06); wrsr(8'h00); chk_status("R4 unlocked");
    wrsr(8'hFC); chk_status("R4 no latch ignored");

    // R9 4-byte addressing
    op_simple(8'hB7); op_simple(8'h06);
    fill(6, 8'h77); pp(32'h0100_0300, 6);
    rd_check(32'h0000_0300, 6, "R9 four byte address");

    // R10 reset sequence
    op_simple(8'h06); op_simple(8'h99); chk_status("R10 lone reset ignored");
    op_simple(8'h66); chk_status("R10 gap"); op_simple(8'h99);
    chk_status("R10 non-adjacent ignored");
    op_simple(8'h66); op_simple(8'h99); chk_status("R10 reset clears latch");
    rd_check(32'h000300, 6, "R10 back to three byte");

    // R11 partial bytes
    cs_lo; for (int i = 7; i >= 1; i--) xbit(1'(8'h06 >> i), q); cs_hi;
    ref_armed = 1'b0; chk_status("R11 partial opcode");
    cs_lo; xbyte(8'hB7, junk); xbit(1'b0, q); xbit(1'b1, q); cs_hi;
    ref_armed = 1'b0;
    rd_check(32'h000300, 2, "R11 partial keeps mode");

    // R8 bulk erase
    op_simple(8'hC7); rd_check(32'h300, 4, "R8 no latch no erase");
    op_simple(8'h06); op_simple(8'hC7);
    rd_check(32'h300, 4, "R8 erased");
    rd_check(32'h210, 4, "R8 erased");

    // random mix
    for (int it = 0; it < 30; it++) begin
      case ($urandom_range(0, 5))
        0: begin
          int n;
          if ($urandom_range(0, 3) != 0) op_simple(8'h06);
          n = $urandom_range(1, 40);
          fill(n, 8'($urandom));
          pp($urandom, n);
        end
        1: rd_check($urandom, $urandom_range(1, 10), "R5 random read");
        2: begin
          if ($urandom_range(0, 1) != 0) op_simple(8'h06);
          se($urandom);
        end
        3: begin
          wp_n = 1'($urandom);
          op_simple(8'h06);
          wrsr(8'($urandom));
        end
        4: begin
          case ($urandom_range(0, 3))
            0: op_simple(8'hB7);
            1: op_simple(8'h66);
            2: op_simple(8'h99);
            default: op_simple(8'h04);
          endcase
        end
        default: chk_status("R3 random status");
      endcase
      rd_check($urandom, 3, "R6 random check");
    end
    chk_status("R4 final status");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule